// File: doc/BRIEF.md
# Compare-Driven Timer Channel

This block is one 16-bit up-counting timer channel for a larger timer subsystem. It advances on a one-cycle count strobe picked from a small set of strobe inputs, so it lives in a single clock domain. The channel can run free across the full count range or fold back to zero after it matches compare value C. That gives a periodic tick. A third setting halts the channel on the C match, which gives a one-shot delay that software restarts.

Two compare values, A and C, act on an output pin. Each has its own programmable action: none, set, clear or toggle. Programming "set on A = 0" and "clear on C = half range" turns the free-running channel into a square wave.

Software uses a synchronous write/read port. Through it, software issues start, stop and restart commands, programs the mode and the compares, reads the count, and reads a status word. That word holds three event flags and a running bit, and a read of it clears the flags. Interrupt mask bits are set through one address and cleared through another. The interrupt output is raised while any flagged event is unmasked.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset the count, the status word (address 5), the mask (read at address 6), the pin `wave_o` and `irq_o` are all 0, and the channel is stopped.
- R2: While the channel is running, each selected strobe adds one to the count. In free-run mode (mode bit 2 = 0), a strobe at 0xFFFF wraps the count to 0 and sets the overflow flag (status bit 2).
- R3: With mode bit 2 = 1 (fold on C), a strobe that finds the count equal to compare C (address 3) loads 0 instead of C+1.
- R4: Writing command (address 0) bit 1 stops the channel. Strobes then leave the count unchanged, and status bit 3 (running) reads 0. Writing command bit 0 resumes counting from the held value.
- R5: A command write carrying both bit 0 (start) and bit 1 (stop) leaves the channel stopped.
- R6: Mode bits [5:4] give the pin action on an A match (address 2), and mode bits [7:6] give the action on a C match. The codes are 0 none, 1 set, 2 clear, 3 toggle. A match is a strobe that finds the count equal to the compare. When A and C match on the same strobe, C's action wins.
- R7: With mode bit 3 = 1 (halt on C), a strobe that finds the count equal to C sets the C flag, keeps the count at C and stops the channel. Further strobes have no effect until a new start command.
- R8: Status bits 0, 1 and 2 flag the A match, the C match and the overflow. Reading the status word returns them and clears them. An event in the same cycle as that read stays flagged.
- R9: Writing address 6 sets the mask bits that are 1 in the data. Writing address 7 clears them, so 0xFF clears the whole mask. `irq_o` is 1 exactly while some flag is set together with its mask bit.
- R10: Mode bits [1:0] choose which `tick_in` bit is the count strobe. The other strobe bits have no effect.
- R11: Command bit 2 (restart) loads the count with 0. A strobe in the cycle of any command write is ignored.
- R12: Read data appears on `rd_data` in the cycle after `rd_en` and holds until the next read. Mode, compare A, compare C and the count read back at addresses 1, 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_in | input | NSRC | Candidate count strobes, one cycle wide |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe for the register port |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | CW | Write data |
| rd_data | output | CW | Registered read data |
| wave_o | output | 1 | Compare-driven waveform pin |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can land in the same cycle: a status read that clears the event flags, and a compare match that sets one of them. The bench sets up this collision directly. It parks the count one below... at exactly the value of compare C, then raises a count strobe in the cycle where it also raises `rd_en` at the status address. The expected result is that this read reports the flags as they stood before the match, and that the next read reports the C flag set. The same clash is checked between command writes and strobes, and between the start and stop bits of a single command.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  localparam int AW    = 3;
  localparam int NFLAG = 3;

  localparam int F_A   = 0;
  localparam int F_C   = 1;
  localparam int F_OVF = 2;

  localparam logic [AW-1:0] ADR_CMD   = 3'd0;
  localparam logic [AW-1:0] ADR_MODE  = 3'd1;
  localparam logic [AW-1:0] ADR_CMPA  = 3'd2;
  localparam logic [AW-1:0] ADR_CMPC  = 3'd3;
  localparam logic [AW-1:0] ADR_COUNT = 3'd4;
  localparam logic [AW-1:0] ADR_STAT  = 3'd5;
  localparam logic [AW-1:0] ADR_MSET  = 3'd6;
  localparam logic [AW-1:0] ADR_MCLR  = 3'd7;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TOG  = 2'd3
  } pin_act_e;

  typedef struct packed {
    pin_act_e   c_act;
    pin_act_e   a_act;
    logic       halt_on_c;
    logic       fold_on_c;
    logic [1:0] src;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              cmd_trig,
  output mode_t             mode,
  output logic [DW-1:0]     cmp_a,
  output logic [DW-1:0]     cmp_c,
  input  logic [NFLAG-1:0]  evt,
  input  logic              running,
  input  logic [DW-1:0]     count,
  output logic              irq
);

  localparam int STAT_W = NFLAG + 1;

  mode_t             mode_q, mode_d;
  logic [DW-1:0]     cmpa_q, cmpa_d;
  logic [DW-1:0]     cmpc_q, cmpc_d;
  logic [NFLAG-1:0]  mask_q, mask_d;
  logic [NFLAG-1:0]  flag_q, flag_d;
  logic [DW-1:0]     rdat_q, rdat_d;
  logic              cmd_wr, stat_rd;

  always_comb begin
    cmd_wr    = wr_en && (addr == ADR_CMD);
    cmd_start = cmd_wr && wr_data[0];
    cmd_stop  = cmd_wr && wr_data[1];
    cmd_trig  = cmd_wr && wr_data[2];
    stat_rd   = rd_en && (addr == ADR_STAT);

    mode_d = mode_q;
    cmpa_d = cmpa_q;
    cmpc_d = cmpc_q;
    mask_d = mask_q;
    if (wr_en) begin
      unique case (addr)
        ADR_MODE: mode_d = mode_t'(wr_data[MODE_W-1:0]);
        ADR_CMPA: cmpa_d = wr_data;
        ADR_CMPC: cmpc_d = wr_data;
        ADR_MSET: mask_d = mask_q | wr_data[NFLAG-1:0];
        ADR_MCLR: mask_d = mask_q & ~wr_data[NFLAG-1:0];
        default:  ;
      endcase
    end

    // a flag raised in the cycle of the clearing read survives it
    flag_d = (stat_rd ? '0 : flag_q) | evt;

    rdat_d = rdat_q;
    if (rd_en) begin
      unique case (addr)
        ADR_MODE:  rdat_d = DW'(mode_q);
        ADR_CMPA:  rdat_d = cmpa_q;
        ADR_CMPC:  rdat_d = cmpc_q;
        ADR_COUNT: rdat_d = count;
        ADR_STAT:  rdat_d = DW'({running, flag_q});
        ADR_MSET:  rdat_d = DW'(mask_q);
        default:   rdat_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cmpa_q <= '0;
      cmpc_q <= '0;
      mask_q <= '0;
      flag_q <= '0;
      rdat_q <= '0;
    end else begin
      mode_q <= mode_d;
      cmpa_q <= cmpa_d;
      cmpc_q <= cmpc_d;
      mask_q <= mask_d;
      flag_q <= flag_d;
      rdat_q <= rdat_d;
    end
  end

  assign mode    = mode_q;
  assign cmp_a   = cmpa_q;
  assign cmp_c   = cmpc_q;
  assign rd_data = rdat_q;
  assign irq     = |(flag_q & mask_q);

  if (STAT_W > DW) begin : g_bad_width
    initial $error("data width too small for status word");
  end

endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core
  import cmp_timer_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NSRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  tick_in,
  input  logic [1:0]       src,
  input  logic             fold_on_c,
  input  logic             halt_on_c,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_trig,
  input  logic [CW-1:0]    cmp_a,
  input  logic [CW-1:0]    cmp_c,
  output logic [CW-1:0]    count,
  output logic             running,
  output logic             hit_a,
  output logic             hit_c,
  output logic             ovf
);

  localparam int NSEL = 4;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [NSEL-1:0] tick_pad;
  logic            tick_sel, step, at_top, halt, fold;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            run_q, run_d;

  for (genvar i = 0; i < NSEL; i++) begin : g_src
    if (i < NSRC) begin : g_used
      assign tick_pad[i] = tick_in[i];
    end else begin : g_tied
      assign tick_pad[i] = 1'b0;
    end
  end

  always_comb begin
    tick_sel = tick_pad[src];
    step     = run_q && tick_sel && !(cmd_start || cmd_stop || cmd_trig);
    hit_a    = step && (cnt_q == cmp_a);
    hit_c    = step && (cnt_q == cmp_c);
    at_top   = step && (cnt_q == CNT_MAX);
    halt     = hit_c && halt_on_c;
    fold     = hit_c && fold_on_c;
    ovf      = at_top && !halt && !fold;

    cnt_d = cnt_q;
    if (cmd_trig)      cnt_d = '0;
    else if (halt)     cnt_d = cnt_q;
    else if (fold)     cnt_d = '0;
    else if (step)     cnt_d = cnt_q + 1'b1;

    run_d = run_q;
    if (cmd_stop)       run_d = 1'b0;
    else if (cmd_start) run_d = 1'b1;
    else if (halt)      run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign count   = cnt_q;
  assign running = run_q;

endmodule

// File: rtl/cmp_timer_wave.sv
module cmp_timer_wave
  import cmp_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hit_a,
  input  logic     hit_c,
  input  pin_act_e a_act,
  input  pin_act_e c_act,
  output logic     pin
);

  logic pin_q, pin_d;

  function automatic logic apply_act(input pin_act_e act, input logic cur);
    unique case (act)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TOG: return !cur;
      default: return cur;
    endcase
  endfunction

  always_comb begin
    pin_d = pin_q;
    if (hit_c)      pin_d = apply_act(c_act, pin_q);
    else if (hit_a) pin_d = apply_act(a_act, pin_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;

endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import cmp_timer_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick_in,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [2:0]      addr,
  input  logic [CW-1:0]   wr_data,
  output logic [CW-1:0]   rd_data,
  output logic            wave_o,
  output logic            irq_o
);

  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  logic              cmd_start, cmd_stop, cmd_trig;
  mode_t             mode;
  logic [CW-1:0]     cmp_a, cmp_c, count;
  logic              running, hit_a, hit_c, ovf;
  logic [NFLAG-1:0]  evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  always_comb begin
    evt        = '0;
    evt[F_A]   = hit_a;
    evt[F_C]   = hit_c;
    evt[F_OVF] = ovf;
  end

  cmp_timer_regs #(.DW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .cmd_trig  (cmd_trig),
    .mode      (mode),
    .cmp_a     (cmp_a),
    .cmp_c     (cmp_c),
    .evt       (evt),
    .running   (running),
    .count     (count),
    .irq       (irq_o)
  );

  cmp_timer_core #(.CW(CW), .NSRC(NSRC)) u_core (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tick_in   (tick_in),
    .src       (mode.src),
    .fold_on_c (mode.fold_on_c),
    .halt_on_c (mode.halt_on_c),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .cmd_trig  (cmd_trig),
    .cmp_a     (cmp_a),
    .cmp_c     (cmp_c),
    .count     (count),
    .running   (running),
    .hit_a     (hit_a),
    .hit_c     (hit_c),
    .ovf       (ovf)
  );

  cmp_timer_wave u_wave (
    .clk   (clk),
    .rst_n (rst_s_n),
    .hit_a (hit_a),
    .hit_c (hit_c),
    .a_act (mode.a_act),
    .c_act (mode.c_act),
    .pin   (wave_o)
  );

endmodule

// File: rtl/cmp_timer_chan_chk.sv
module cmp_timer_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_s_n,
  input logic          cmd_start,
  input logic          cmd_stop,
  input logic          cmd_trig,
  input logic          running,
  input logic          hit_c,
  input logic          fold_on_c,
  input logic          halt_on_c,
  input logic [CW-1:0] count,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [CW-1:0] wr_data,
  input logic          irq_o
);

  logic no_cmd;
  assign no_cmd = !(cmd_start || cmd_stop || cmd_trig);

  // R4: a stopped channel with no command keeps its count
  p_stop_holds_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!running && no_cmd) |=> $stable(count));

  // R5: stop wins over start
  p_stop_prio_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_stop && cmd_start) |=> !running);

  // R3: fold on C match returns count to zero
  p_fold_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hit_c && fold_on_c && !halt_on_c) |=> (count == '0));

  // R7: halt on C match stops the channel at C
  p_halt_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hit_c && halt_on_c) |=> (!running && $stable(count)));

  // R11: restart loads zero
  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    cmd_trig |=> (count == '0));

  // R9: clearing every mask bit silences the interrupt
  p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && addr == 3'd7 && (&wr_data[2:0])) |=> !irq_o);

endmodule

bind cmp_timer_chan cmp_timer_chan_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .cmd_start (cmd_start),
  .cmd_stop  (cmd_stop),
  .cmd_trig  (cmd_trig),
  .running   (running),
  .hit_c     (hit_c),
  .fold_on_c (mode.fold_on_c),
  .halt_on_c (mode.halt_on_c),
  .count     (count),
  .wr_en     (wr_en),
  .addr      (addr),
  .wr_data   (wr_data),
  .irq_o     (irq_o)
);

// File: tb/cmp_timer_chan_bench.sv
`timescale 1ns/1ps
module cmp_timer_chan_bench;

  localparam int CW   = 16;
  localparam int NSRC = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] tick_in = '0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [2:0]      addr = '0;
  logic [CW-1:0]   wr_data = '0;
  logic [CW-1:0]   rd_data;
  logic            wave_o, irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic pend = 1'b0;
  logic [CW-1:0] exp_q[$];
  string         tag_q[$];

  always #2 clk = ~clk;

  cmp_timer_chan #(.CW(CW), .NSRC(NSRC)) u_cmp_timer_chan (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .wave_o(wave_o), .irq_o(irq_o)
  );

  // monitor: read data is valid one cycle after rd_en (R12)
  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) begin
    if (pend) begin
      logic [CW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rd_data !== e) begin
        n_bad++;
        $display("FAIL %s: read got 0x%0h expected 0x%0h", t, rd_data, e);
      end
    end
  end

  task automatic chk(input string t, input logic act, input logic e);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [CW-1:0] e, input string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick(input int n, input int idx);
    for (int i = 0; i < n; i++) begin
      tick_in[idx] = 1'b1;
      @(negedge clk);
      tick_in[idx] = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd5, 16'h0000, "R1 status");
    rd(3'd4, 16'h0000, "R1 count");
    rd(3'd6, 16'h0000, "R1 mask");
    chk("R1 pin", wave_o, 1'b0);
    chk("R1 irq", irq_o, 1'b0);

    // R6/R2: A=0 set, C=8 clear, free run
    wr(3'd1, 16'h0090);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0008);
    rd(3'd1, 16'h0090, "R12 mode readback");
    rd(3'd3, 16'h0008, "R12 cmpC readback");
    wr(3'd0, 16'h0005);
    tick(5, 0);
    rd(3'd4, 16'd5, "R2 count after 5 strobes");
    chk("R6 pin set on A match", wave_o, 1'b1);
    tick(4, 0);
    chk("R6 pin cleared on C match", wave_o, 1'b0);
    rd(3'd5, 16'h000B, "R8 status A,C,run");
    rd(3'd5, 16'h0008, "R8 flags cleared by read");

    // R4 stop holds count
    wr(3'd0, 16'h0002);
    tick(3, 0);
    rd(3'd4, 16'd9, "R4 count held while stopped");
    rd(3'd5, 16'h0000, "R4 running bit low");

    // R5 start+stop together
    wr(3'd0, 16'h0003);
    tick(2, 0);
    rd(3'd4, 16'd9, "R5 stop wins");
    wr(3'd0, 16'h0001);
    tick(2, 0);
    rd(3'd4, 16'd11, "R4 resume from held value");

    // R11 restart, R3 fold on C
    wr(3'd1, 16'h0094);
    wr(3'd3, 16'h0003);
    wr(3'd0, 16'h0005);
    rd(3'd4, 16'd0, "R11 restart loads zero");
    tick(4, 0);
    rd(3'd4, 16'd0, "R3 fold on C");
    tick(2, 0);
    rd(3'd4, 16'd2, "R3 count after fold");

    // R7 one-shot
    wr(3'd1, 16'h009C);
    wr(3'd0, 16'h0005);
    tick(6, 0);
    rd(3'd4, 16'd3, "R7 halted at C");
    rd(3'd5, 16'h0003, "R7 stopped with flags");
    wr(3'd0, 16'h0005);
    tick(2, 0);
    rd(3'd4, 16'd2, "R7 restart after halt");

    // R9 mask and irq
    rd(3'd5, 16'h0009, "R8 status before mask test");
    wr(3'd6, 16'h0002);
    rd(3'd6, 16'h0002, "R9 mask set");
    chk("R9 irq idle", irq_o, 1'b0);
    tick(2, 0);
    chk("R9 irq on C flag", irq_o, 1'b1);
    wr(3'd7, 16'h00FF);
    chk("R9 irq after clear-all", irq_o, 1'b0);
    rd(3'd6, 16'h0000, "R9 mask cleared");
    wr(3'd6, 16'h0005);
    rd(3'd6, 16'h0005, "R9 mask set again");

    // R2 overflow
    rd(3'd5, 16'h0002, "R8 pending C flag");
    wr(3'd1, 16'h0090);
    wr(3'd0, 16'h0005);
    tick(65536, 0);
    rd(3'd4, 16'd0, "R2 wrapped to zero");
    chk("R9 irq from A/overflow", irq_o, 1'b1);
    rd(3'd5, 16'h000F, "R2 overflow flag");

    // R8 collision: clearing read with a C match in the same cycle
    wr(3'd0, 16'h0005);
    tick(3, 0);
    rd(3'd5, 16'h0009, "R8 pre-collision status");
    rd_en = 1'b1; addr = 3'd5; tick_in[0] = 1'b1;
    exp_q.push_back(16'h0008); tag_q.push_back("R8 read during match");
    @(negedge clk);
    rd_en = 1'b0; tick_in[0] = 1'b0;
    rd(3'd5, 16'h000A, "R8 event survives clearing read");

    // R11 strobe with a command write is ignored
    wr(3'd0, 16'h0005);
    tick_in[0] = 1'b1; wr(3'd0, 16'h0001); tick_in[0] = 1'b0;
    rd(3'd4, 16'd0, "R11 strobe during command ignored");

    // R10 source select
    wr(3'd1, 16'h0091);
    wr(3'd0, 16'h0005);
    tick(3, 0);
    rd(3'd4, 16'd0, "R10 unselected strobe ignored");
    tick(2, 1);
    rd(3'd4, 16'd2, "R10 selected strobe counts");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule